// File: doc/BRIEF.md
# Multi-Channel Conversion Scheduler

This block decides which analog input is converted next and when. It sits between a sample trigger source and an external successive-approximation conversion core. When a trigger is accepted, it sends the core a channel number and a one-cycle start pulse. It waits for the core's done strobe, then writes the formatted result into a small register file that has one entry per channel. In the sequence modes it walks down from a chosen start channel to channel 0 on its own. A trigger that arrives while work is in progress sets a sticky overflow flag, and a one-cycle transfer request tells a DMA engine when results are ready to move.

Configuration is plain level inputs. These are the mode, the start channel and the justification select. They are sampled only when a trigger is accepted, so they may change at any time without disturbing a conversion in progress. The core's result port is a strobe with no ready signal: the core may never be stalled, so the block accepts every done strobe that arrives while it is waiting for one. Results are read through a combinational read port indexed by channel.

Top module: `adcseq_top`

## Requirements
- R1: After reset, busy, ovf, dma_req and core_start are low and every result entry reads zero.
- R2: Mode 0 (single, once): an accepted trigger converts the start channel once. Afterwards the scheduler stays parked with busy low and ignores triggers (no core_start, no ovf) until enable is seen low.
- R3: Mode 1 (single, repeated): each accepted trigger converts the start channel once and returns to idle, ready for the next trigger without any enable toggle.
- R4: Modes 2 and 3 (sequence): one accepted trigger converts the start channel first, then each lower channel down to channel 0. Each channel gets exactly one core_start. A start channel of 0 gives a single conversion.
- R5: Mode 2 parks after channel 0 exactly like mode 0. Mode 3 returns to idle after channel 0, so the next trigger restarts the walk from the start channel.
- R6: A trigger while busy is high sets ovf on the next cycle. The trigger itself is dropped and the running conversion or sequence finishes unchanged. ovf stays set until ovf_clr is pulsed; set wins over clear.
- R7: dma_req is a one-cycle pulse in the cycle after the done strobe. In modes 0 and 1 it follows every conversion. In modes 2 and 3 it follows only the channel 0 conversion.
- R8: With left_just=0, the 10-bit result lands in bits [9:0] of the 16-bit entry and bits [15:10] are zero. With left_just=1, it lands in bits [15:6] and bits [5:0] are zero.
- R9: On a done strobe, the result is written to the entry indexed by the channel being converted. It is readable on the next cycle, and all other entries keep their values.
- R10: busy rises in the cycle after an accepted trigger and stays high until the last done strobe of the job. mode, start_ch and left_just are sampled only at acceptance.
- R11: core_start lasts exactly one cycle per channel, and core_ch holds steady from that pulse until the matching done strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig | input | 1 | Sample-and-convert request |
| enable | input | 1 | Triggers are accepted only while high; low releases the parked state |
| mode | input | 2 | 0 single, 1 repeat single, 2 sequence, 3 repeat sequence |
| start_ch | input | 3 | Converted channel, or first channel of a sequence |
| left_just | input | 1 | 1 puts the result in the upper bits of the entry |
| ovf_clr | input | 1 | Clears the overflow flag |
| core_start | output | 1 | One-cycle start pulse to the conversion core |
| core_ch | output | 3 | Channel select to the core |
| core_done | input | 1 | Core strobe: result valid this cycle |
| core_data | input | 10 | Core result |
| busy | output | 1 | Job in progress |
| ovf | output | 1 | Sticky overflow flag |
| dma_req | output | 1 | One-cycle transfer request |
| rd_ch | input | 3 | Result read index |
| rd_data | output | 16 | Result entry at rd_ch |

## Verification
If the channel register holds a wrong value, the failure appears at the next start pulse: core_ch goes out of order, and the result lands in a neighbouring entry, which the read port shows one cycle after the done strobe. If the mode register is wrong, the fault shows as a wrong count of dma_req pulses, or as a trigger honoured or dropped against the parked rule. Both are visible within one job. If the justification register is wrong, the fault shows in the first entry written after acceptance.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {
    MODE_ONE     = 2'd0,
    MODE_REP_ONE = 2'd1,
    MODE_SEQ     = 2'd2,
    MODE_REP_SEQ = 2'd3
  } seq_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2,
    ST_PARK   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  input  logic            enable,
  input  logic [1:0]      mode,
  input  logic [CH_W-1:0] start_ch,
  input  logic            left_just,
  input  logic            ovf_clr,
  input  logic            core_done,
  output logic            core_start,
  output logic [CH_W-1:0] core_ch,
  output logic            busy,
  output logic            ovf,
  output logic            dma_req,
  output logic            wr_en,
  output logic [CH_W-1:0] wr_ch,
  output logic            wr_left
);
  seq_state_e      state_q;
  seq_mode_e       mode_q;
  logic [CH_W-1:0] ch_q;
  logic            just_q;
  logic            accept;
  logic            last_conv;
  logic            is_seq;
  logic            is_rep;

  assign is_seq    = mode_q[1];
  assign is_rep    = mode_q[0];
  assign busy      = (state_q == ST_LAUNCH) || (state_q == ST_WAIT);
  assign accept    = (state_q == ST_IDLE) && trig && enable;
  assign core_start = (state_q == ST_LAUNCH);
  assign core_ch   = ch_q;
  assign wr_en     = (state_q == ST_WAIT) && core_done;
  assign wr_ch     = ch_q;
  assign wr_left   = just_q;
  assign last_conv = !is_seq || (ch_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_ONE;
      ch_q    <= '0;
      just_q  <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      dma_req <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            mode_q  <= seq_mode_e'(mode);
            ch_q    <= start_ch;
            just_q  <= left_just;
            state_q <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (core_done) begin
            if (last_conv) begin
              dma_req <= 1'b1;
              state_q <= is_rep ? ST_IDLE : ST_PARK;
            end else begin
              ch_q    <= ch_q - 1'b1;
              state_q <= ST_LAUNCH;
            end
          end
        end
        ST_PARK: begin
          if (!enable) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ovf <= 1'b0;
    else if (trig && busy)    ovf <= 1'b1;
    else if (ovf_clr)         ovf <= 1'b0;
  end
endmodule

// File: rtl/adcseq_fmt.sv
module adcseq_fmt #(
  parameter int RES_W  = 10,
  parameter int WORD_W = 16
) (
  input  logic [RES_W-1:0]  raw,
  input  logic              left,
  output logic [WORD_W-1:0] word
);
  localparam int PAD_W = WORD_W - RES_W;

  always_comb begin
    if (left) word = {raw, {PAD_W{1'b0}}};
    else      word = {{PAD_W{1'b0}}, raw};
  end
endmodule

// File: rtl/adcseq_regfile.sv
module adcseq_regfile #(
  parameter int NCH    = 8,
  parameter int CH_W   = 3,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [CH_W-1:0]   rd_ch,
  output logic [WORD_W-1:0] rd_word
);
  logic [WORD_W-1:0] entry_q [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        entry_q[g] <= '0;
      else if (wr_en && (wr_ch == CH_W'(g)))
        entry_q[g] <= wr_word;
    end
  end

  assign rd_word = entry_q[rd_ch];
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top #(
  parameter int NCH    = 8,
  parameter int RES_W  = 10,
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     trig,
  input  logic                     enable,
  input  logic [1:0]               mode,
  input  logic [$clog2(NCH)-1:0]   start_ch,
  input  logic                     left_just,
  input  logic                     ovf_clr,
  output logic                     core_start,
  output logic [$clog2(NCH)-1:0]   core_ch,
  input  logic                     core_done,
  input  logic [RES_W-1:0]         core_data,
  output logic                     busy,
  output logic                     ovf,
  output logic                     dma_req,
  input  logic [$clog2(NCH)-1:0]   rd_ch,
  output logic [WORD_W-1:0]        rd_data
);
  localparam int CH_W = $clog2(NCH);

  logic              wr_en;
  logic [CH_W-1:0]   wr_ch;
  logic              wr_left;
  logic [WORD_W-1:0] wr_word;

  adcseq_ctrl #(.CH_W(CH_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .trig(trig), .enable(enable), .mode(mode),
    .start_ch(start_ch), .left_just(left_just), .ovf_clr(ovf_clr),
    .core_done(core_done), .core_start(core_start), .core_ch(core_ch),
    .busy(busy), .ovf(ovf), .dma_req(dma_req), .wr_en(wr_en),
    .wr_ch(wr_ch), .wr_left(wr_left)
  );

  adcseq_fmt #(.RES_W(RES_W), .WORD_W(WORD_W)) u_fmt (
    .raw(core_data), .left(wr_left), .word(wr_word)
  );

  adcseq_regfile #(.NCH(NCH), .CH_W(CH_W), .WORD_W(WORD_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_word(wr_word), .rd_ch(rd_ch), .rd_word(rd_data)
  );
endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
  parameter int CH_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trig,
  input logic            ovf_clr,
  input logic            core_start,
  input logic            core_done,
  input logic [CH_W-1:0] core_ch,
  input logic            busy,
  input logic            ovf,
  input logic            dma_req
);
  p_start_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);

  p_ch_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !core_done) |=> $stable(core_ch));

  p_dma_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req);

  p_dma_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> $past(core_done));

  p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && busy) |=> ovf);

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf);

  p_no_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !core_start);
endmodule

bind adcseq_top adcseq_chk #(.CH_W($clog2(NCH))) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .ovf_clr(ovf_clr),
  .core_start(core_start), .core_done(core_done), .core_ch(core_ch),
  .busy(busy), .ovf(ovf), .dma_req(dma_req)
);

// File: tb/adcseq_top_bench.sv
module adcseq_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;

  logic       clk = 1'b0;
  logic       rst_n, trig, enable, left_just, ovf_clr, core_done;
  logic [1:0] mode;
  logic [2:0] start_ch, rd_ch, core_ch;
  logic [9:0] core_data;
  logic       core_start, busy, ovf, dma_req;
  logic [15:0] rd_data;

  int n_chk = 0, n_bad = 0;
  int start_cnt = 0, dma_cnt = 0, nconv = 0;
  bit exp_just = 0;
  bit finished = 0;
  int exp_ch_q[$];
  int res_ch_q[$];
  int res_word_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  adcseq_top u_adcseq_top (
    .clk(clk), .rst_n(rst_n), .trig(trig), .enable(enable), .mode(mode),
    .start_ch(start_ch), .left_just(left_just), .ovf_clr(ovf_clr),
    .core_start(core_start), .core_ch(core_ch), .core_done(core_done),
    .core_data(core_data), .busy(busy), .ovf(ovf), .dma_req(dma_req),
    .rd_ch(rd_ch), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // core stub: checks channel order (R4, R11), produces data, queues expected results
  initial begin
    core_done = 1'b0;
    core_data = '0;
    forever begin
      @(negedge clk);
      core_done = 1'b0;
      if (core_start) begin
        int ch, raw, exp_c;
        start_cnt++;
        ch = int'(core_ch);
        if (exp_ch_q.size() == 0) check(0, "R4 unexpected start", ch, -1);
        else begin
          exp_c = exp_ch_q.pop_front();
          check(ch == exp_c, "R4 channel order", ch, exp_c);
        end
        repeat (LAT) @(negedge clk);
        raw = (ch * 53 + nconv * 29 + 7) % 1024;
        nconv++;
        check(int'(core_ch) == ch, "R11 core_ch held", int'(core_ch), ch);
        core_data = 10'(raw);
        core_done = 1'b1;
        res_ch_q.push_back(ch);
        res_word_q.push_back(exp_just ? (raw << 6) : raw);
      end
    end
  end

  // monitor: result written on done strobe, read back next cycle (R8, R9)
  initial begin
    forever begin
      @(posedge clk); #1;
      if (core_done && res_ch_q.size() > 0) begin
        int ch, w;
        ch = res_ch_q.pop_front();
        w  = res_word_q.pop_front();
        rd_ch = 3'(ch);
        #1;
        check(int'(rd_data) == w, "R8 R9 result entry", int'(rd_data), w);
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (dma_req) dma_cnt++;
  end

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!busy && exp_ch_q.size() == 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  // driver: queue expected channels, fire one trigger, wait for completion
  task automatic run(input int m, input int sc, input bit lj, input int exp_dma, input string req);
    int d0;
    @(negedge clk);
    mode = 2'(m); start_ch = 3'(sc); left_just = lj; exp_just = lj;
    if (m >= 2) for (int c = sc; c >= 0; c--) exp_ch_q.push_back(c);
    else exp_ch_q.push_back(sc);
    d0 = dma_cnt;
    trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    check(busy == 1'b1, "R10 busy after accept", int'(busy), 1);
    wait_idle();
    check(exp_ch_q.size() == 0, {req, " all channels started"}, exp_ch_q.size(), 0);
    check(dma_cnt - d0 == exp_dma, {"R7 dma count ", req}, dma_cnt - d0, exp_dma);
  endtask

  task automatic park_check(input string req);
    int s0;
    s0 = start_cnt;
    pulse_trig();
    repeat (8) @(negedge clk);
    check(start_cnt == s0, {req, " parked trigger ignored"}, start_cnt - s0, 0);
    check(ovf == 1'b0, {req, " parked no ovf"}, int'(ovf), 0);
    @(negedge clk); enable = 1'b0;
    @(negedge clk); enable = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; trig = 1'b0; enable = 1'b1; mode = 2'd0; start_ch = '0;
    left_just = 1'b0; ovf_clr = 1'b0; rd_ch = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !ovf && !dma_req && !core_start, "R1 reset outputs",
          int'({busy, ovf, dma_req, core_start}), 0);
    for (int c = 0; c < 8; c++) begin
      rd_ch = 3'(c); #1;
      check(rd_data == 16'd0, "R1 reset entry", int'(rd_data), 0);
    end

    // R2 single once, right justified, then parked
    run(0, 5, 1'b0, 1, "R2");
    park_check("R2");
    @(negedge clk); rd_ch = 3'd4; #1;
    check(rd_data == 16'd0, "R9 other entry untouched", int'(rd_data), 0);

    // R3 repeat single, left justified, twice without enable toggle
    run(1, 3, 1'b1, 1, "R3");
    run(1, 3, 1'b1, 1, "R3");

    // R4 R5 sequence once from 3, then parked
    run(2, 3, 1'b0, 1, "R4 R5");
    park_check("R5");

    // R5 repeat sequence restarts from start channel
    run(3, 2, 1'b1, 1, "R5");
    run(3, 2, 1'b1, 1, "R5");

    // R4 sequence from channel 0 gives a single conversion
    run(3, 0, 1'b0, 1, "R4 ch0");

    // R6 R10: trigger and config change during a running sequence
    begin
      int d0;
      @(negedge clk);
      mode = 2'd2; start_ch = 3'd4; left_just = 1'b0; exp_just = 1'b0;
      for (int c = 4; c >= 0; c--) exp_ch_q.push_back(c);
      d0 = dma_cnt;
      trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      repeat (2) @(negedge clk);
      mode = 2'd0; start_ch = 3'd7; left_just = 1'b1;
      trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      @(negedge clk);
      check(ovf == 1'b1, "R6 ovf set", int'(ovf), 1);
      check(busy == 1'b1, "R6 conversion not aborted", int'(busy), 1);
      wait_idle();
      check(exp_ch_q.size() == 0, "R10 sequence kept latched config", exp_ch_q.size(), 0);
      check(dma_cnt - d0 == 1, "R7 dma once per sequence", dma_cnt - d0, 1);
      check(ovf == 1'b1, "R6 ovf sticky", int'(ovf), 1);
      @(negedge clk); ovf_clr = 1'b1;
      @(negedge clk); ovf_clr = 1'b0;
      check(ovf == 1'b0, "R6 ovf cleared", int'(ovf), 0);
      park_check("R5");
    end

    check(res_ch_q.size() == 0, "R9 all results observed", res_ch_q.size(), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog expired", 0, 1);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule